// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges reset requests from four sources into one reset sequence. The sources are loss of PLL lock, loss of clock, a core watchdog or debug command, and a boundary-scan instruction that forces a system reset. When a request is accepted, the block drives an internal reset and an external reset-out. At that moment it latches the wake-up and PLL configuration inputs.

Release is staged. The sequence waits until every accepted request has gone away, then counts a programmable number of cycles. It then samples the boot configuration pins for one cycle, holds reset for four more cycles, and drops it. At the moment of release, a one-hot status register records which source caused the reset.

A request that arrives during the counting, sampling or final delay phases restarts the sequence. While a boundary-scan reset is in progress, reset-out follows a level supplied by the test controller rather than the sequencer.

Top module: `rstseq_ctrl`

## Requirements
- R1: After `rst_n` is deasserted, `int_rst` and `rst_out` are low and `rst_status` is all zeros.
- R2: When idle, an accepted request raises `int_rst` and `rst_out` at the next rising clock edge. The accepted requests are: lock loss, watchdog/debug, clock loss while its enable is set, and the reset instruction while the test port is enabled.
- R3: `wake_cfg_q` and `pll_cfg_q` take the values that `wake_cfg_in` and `pll_cfg_in` had at the edge where `int_rst` rises, and keep them afterwards.
- R4: The release phase starts only in the cycle after no accepted request is active. An unrelated lock-loss request therefore prolongs a watchdog reset.
- R5: The count phase lasts `max(wait_n,1)` cycles. From the edge where requests are seen released, reset stays high for `max(wait_n,1)+5` cycles.
- R6: `boot_cfg_q` holds the value the boot pins had during the single cycle after the count phase. Exactly 4 cycles later, both `int_rst` and `rst_out` fall.
- R7: `rst_status` is one-hot with bit 0 = clock loss, bit 1 = lock loss, bit 2 = watchdog/debug and bit 3 = boundary-scan. It is written only on the edge where reset is released, and all other bits are then cleared.
- R8: Requests that start in the same cycle are ranked clock loss, then lock loss, then watchdog/debug, then boundary-scan. Only the highest-ranked one is recorded.
- R9: A new accepted request during the count, sample or delay phase returns the sequence to the assert phase. It recaptures the wake-up and PLL values and makes that request the recorded cause.
- R10: While a boundary-scan reset is in progress, `rst_out` equals `jtag_rstout_lvl`.
- R11: A clock-loss request with its enable clear, or a reset instruction with the test port disabled, has no effect on `int_rst`, `rst_out` or `rst_status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| wait_n | input | CNT_W | Length of the count phase in cycles |
| req_lock_loss | input | 1 | PLL loss-of-lock request |
| req_clk_loss | input | 1 | Clock loss request |
| clk_loss_rst_en | input | 1 | Allows clock loss to cause reset |
| req_wdog_dbg | input | 1 | Watchdog or debug reset request |
| jtag_en | input | 1 | Test port enabled |
| jtag_rst_instr | input | 1 | A reset-forcing scan instruction is active |
| jtag_rstout_lvl | input | 1 | Reset-out level chosen by the test controller |
| wake_cfg_in | input | WAKE_W | Wake-up configuration input |
| pll_cfg_in | input | PLL_W | PLL configuration input |
| boot_cfg_pins | input | BOOT_W | Boot configuration pins |
| int_rst | output | 1 | Internal reset |
| rst_out | output | 1 | External reset-out |
| wake_cfg_q | output | WAKE_W | Latched wake-up configuration |
| pll_cfg_q | output | PLL_W | Latched PLL configuration |
| boot_cfg_q | output | BOOT_W | Sampled boot configuration |
| rst_status | output | 4 | One-hot cause of the last completed reset |

## Verification
The bench drives the boot pins to the wanted value only during the one sampling cycle, and to the complement before and after. A sequencer that samples one cycle early or late therefore latches the inverted pattern. Wake-up inputs change right after assertion, so late capture shows up as a wrong latched value. The bench measures each reset pulse in whole cycles. This catches a release that ignores a lingering lock-loss request, a count phase off by one, and a zero count treated as zero cycles. Further cases cover a request landing mid-count that must restart the sequence and change the cause, simultaneous requests that must pick the top-ranked source, and gated requests that must leave the outputs untouched.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  localparam int NUM_SRC      = 4;
  localparam int SRC_CLK      = 0;
  localparam int SRC_LOCK     = 1;
  localparam int SRC_WDOG     = 2;
  localparam int SRC_JTAG     = 3;
  localparam int DELAY_CYCLES = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ASSERT,
    ST_WAIT_REL,
    ST_COUNT,
    ST_SAMPLE,
    ST_DELAY,
    ST_RELEASE
  } seq_state_e;

  // keep only the lowest set bit: lowest index has highest rank
  function automatic logic [NUM_SRC-1:0] pick_cause(input logic [NUM_SRC-1:0] req);
    return req & (~req + NUM_SRC'(1));
  endfunction

  // a phase of length L lasts max(L,1) cycles; counter starts at 1
  function automatic logic phase_done(input int unsigned cnt, input int unsigned len);
    int unsigned eff;
    eff = (len == 0) ? 1 : len;
    return cnt >= eff;
  endfunction

endpackage

// File: rtl/rstseq_req_arb.sv
module rstseq_req_arb
  import rstseq_pkg::*;
(
  input  logic               req_clk_loss,
  input  logic               clk_loss_rst_en,
  input  logic               req_lock_loss,
  input  logic               req_wdog_dbg,
  input  logic               jtag_en,
  input  logic               jtag_rst_instr,
  output logic [NUM_SRC-1:0] acc_vec,
  output logic [NUM_SRC-1:0] win_vec,
  output logic               any_acc
);

  always_comb begin
    acc_vec           = '0;
    acc_vec[SRC_CLK]  = req_clk_loss & clk_loss_rst_en;
    acc_vec[SRC_LOCK] = req_lock_loss;
    acc_vec[SRC_WDOG] = req_wdog_dbg;
    acc_vec[SRC_JTAG] = jtag_en & jtag_rst_instr;
  end

  assign win_vec = pick_cause(acc_vec);
  assign any_acc = |acc_vec;

endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer
  import rstseq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt_q,
  output logic             done
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign done = phase_done(32'(cnt_q), 32'(limit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= ONE;
    else if (clear)        cnt_q <= ONE;
    else if (run && !done) cnt_q <= cnt_q + ONE;
  end

  // R5: while running, the counter never passes the effective phase length
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clear && $stable(limit)) |-> (32'(cnt_q) <= ((limit == '0) ? 32'd1 : 32'(limit))));

endmodule

// File: rtl/rstseq_cfg_cap.sv
module rstseq_cfg_cap #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int WAKE_W = 4,
  parameter int PLL_W  = 2,
  parameter int BOOT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  wait_n,
  input  logic              req_lock_loss,
  input  logic              req_clk_loss,
  input  logic              clk_loss_rst_en,
  input  logic              req_wdog_dbg,
  input  logic              jtag_en,
  input  logic              jtag_rst_instr,
  input  logic              jtag_rstout_lvl,
  input  logic [WAKE_W-1:0] wake_cfg_in,
  input  logic [PLL_W-1:0]  pll_cfg_in,
  input  logic [BOOT_W-1:0] boot_cfg_pins,
  output logic              int_rst,
  output logic              rst_out,
  output logic [WAKE_W-1:0] wake_cfg_q,
  output logic [PLL_W-1:0]  pll_cfg_q,
  output logic [BOOT_W-1:0] boot_cfg_q,
  output logic [3:0]        rst_status
);

  localparam logic [CNT_W-1:0] DLY_LEN = CNT_W'(DELAY_CYCLES);

  seq_state_e         state_q, state_d;
  logic [NUM_SRC-1:0] acc_vec, win_vec, cause_q, status_q;
  logic               any_acc;
  logic [CNT_W-1:0]   tmr_cnt, tmr_limit;
  logic               tmr_done, tmr_clear, tmr_run;

  // named internal events
  logic ev_accept, ev_release_go, ev_sample, ev_status_wr, restartable;

  rstseq_req_arb u_arb (
    .req_clk_loss    (req_clk_loss),
    .clk_loss_rst_en (clk_loss_rst_en),
    .req_lock_loss   (req_lock_loss),
    .req_wdog_dbg    (req_wdog_dbg),
    .jtag_en         (jtag_en),
    .jtag_rst_instr  (jtag_rst_instr),
    .acc_vec         (acc_vec),
    .win_vec         (win_vec),
    .any_acc         (any_acc)
  );

  assign restartable = (state_q == ST_IDLE)  || (state_q == ST_COUNT) ||
                       (state_q == ST_SAMPLE) || (state_q == ST_DELAY) ||
                       (state_q == ST_RELEASE);
  assign ev_accept     = restartable && any_acc;
  assign ev_release_go = (state_q == ST_WAIT_REL) && !any_acc;
  assign ev_sample     = (state_q == ST_SAMPLE);
  assign ev_status_wr  = (state_q == ST_DELAY) && tmr_done && !any_acc;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_RELEASE: state_d = any_acc ? ST_ASSERT : ST_IDLE;
      ST_ASSERT:           state_d = ST_WAIT_REL;
      ST_WAIT_REL:         state_d = any_acc ? ST_WAIT_REL : ST_COUNT;
      ST_COUNT:            state_d = any_acc ? ST_ASSERT : (tmr_done ? ST_SAMPLE : ST_COUNT);
      ST_SAMPLE:           state_d = any_acc ? ST_ASSERT : ST_DELAY;
      ST_DELAY:            state_d = any_acc ? ST_ASSERT : (tmr_done ? ST_RELEASE : ST_DELAY);
      default:             state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cause_q  <= '0;
      status_q <= '0;
    end else begin
      state_q <= state_d;
      if (ev_accept)    cause_q  <= win_vec;
      if (ev_status_wr) status_q <= cause_q;
    end
  end

  // one shared timer: count phase uses wait_n, delay phase uses the fixed length
  assign tmr_limit = (state_q == ST_DELAY) ? DLY_LEN : wait_n;
  assign tmr_run   = (state_q == ST_COUNT) || (state_q == ST_DELAY);
  assign tmr_clear = ev_release_go || (ev_sample && !any_acc);

  rstseq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (tmr_clear),
    .run   (tmr_run),
    .limit (tmr_limit),
    .cnt_q (tmr_cnt),
    .done  (tmr_done)
  );

  rstseq_cfg_cap #(.W(WAKE_W)) u_wake (
    .clk (clk), .rst_n (rst_n), .load (ev_accept), .d (wake_cfg_in), .q (wake_cfg_q)
  );

  rstseq_cfg_cap #(.W(PLL_W)) u_pll (
    .clk (clk), .rst_n (rst_n), .load (ev_accept), .d (pll_cfg_in), .q (pll_cfg_q)
  );

  rstseq_cfg_cap #(.W(BOOT_W)) u_boot (
    .clk (clk), .rst_n (rst_n), .load (ev_sample), .d (boot_cfg_pins), .q (boot_cfg_q)
  );

  assign int_rst    = (state_q != ST_IDLE) && (state_q != ST_RELEASE);
  assign rst_out    = cause_q[SRC_JTAG] ? (int_rst & jtag_rstout_lvl) : int_rst;
  assign rst_status = status_q;

  // R7: at most one cause recorded
  a_r7_status_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rst_status));

  // R7: status moves only as reset is released
  a_r7_status_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rst_status) |-> (state_q == ST_RELEASE));

  // R2: idle plus accepted request gives reset on the next cycle
  a_r2_req_asserts: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && any_acc) |=> (int_rst && rst_out == (cause_q[SRC_JTAG] ? jtag_rstout_lvl : 1'b1)));

  // R3: wake-up configuration taken from the accepting edge
  a_r3_wake_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && any_acc) |=> (wake_cfg_q == $past(wake_cfg_in)));

  // R4: no release while any accepted request persists
  a_r4_hold_while_req: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT_REL && any_acc) |=> (state_q == ST_WAIT_REL));

  // R6: the sample cycle is followed by the fixed delay
  a_r6_sample_then_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sample && !any_acc) |=> (state_q == ST_DELAY && tmr_cnt == CNT_W'(1)));

  // R9: late request restarts the sequence
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_COUNT || state_q == ST_SAMPLE || state_q == ST_DELAY) && any_acc)
      |=> (state_q == ST_ASSERT));

  // R8: recorded cause is a single source after acceptance
  a_r8_single_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> $onehot(cause_q));

endmodule

// File: tb/rstseq_ctrl_tb.sv
`timescale 1ns/1ps
module rstseq_ctrl_tb;

  localparam int CNT_W = 8, WAKE_W = 4, PLL_W = 2, BOOT_W = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n;
  logic [CNT_W-1:0]  wait_n;
  logic              req_lock_loss, req_clk_loss, clk_loss_rst_en, req_wdog_dbg;
  logic              jtag_en, jtag_rst_instr, jtag_rstout_lvl;
  logic [WAKE_W-1:0] wake_cfg_in;
  logic [PLL_W-1:0]  pll_cfg_in;
  logic [BOOT_W-1:0] boot_cfg_pins;
  logic              int_rst, rst_out;
  logic [WAKE_W-1:0] wake_cfg_q;
  logic [PLL_W-1:0]  pll_cfg_q;
  logic [BOOT_W-1:0] boot_cfg_q;
  logic [3:0]        rst_status;

  rstseq_ctrl #(.CNT_W(CNT_W), .WAKE_W(WAKE_W), .PLL_W(PLL_W), .BOOT_W(BOOT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wait_n(wait_n),
    .req_lock_loss(req_lock_loss), .req_clk_loss(req_clk_loss),
    .clk_loss_rst_en(clk_loss_rst_en), .req_wdog_dbg(req_wdog_dbg),
    .jtag_en(jtag_en), .jtag_rst_instr(jtag_rst_instr), .jtag_rstout_lvl(jtag_rstout_lvl),
    .wake_cfg_in(wake_cfg_in), .pll_cfg_in(pll_cfg_in), .boot_cfg_pins(boot_cfg_pins),
    .int_rst(int_rst), .rst_out(rst_out), .wake_cfg_q(wake_cfg_q),
    .pll_cfg_q(pll_cfg_q), .boot_cfg_q(boot_cfg_q), .rst_status(rst_status)
  );

  typedef struct {
    logic [3:0]        status;
    int                len;
    logic [WAKE_W-1:0] wake;
    logic [PLL_W-1:0]  pll;
    logic [BOOT_W-1:0] boot;
    bit                jtag;
  } exp_t;

  exp_t q[$];
  exp_t got;
  int n_chk = 0, n_bad = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // inputs change 1 ns after each falling edge; the monitor samples on falling edges
  task automatic tick();
    @(negedge clk);
    #1;
    jtag_rstout_lvl = ~jtag_rstout_lvl;
  endtask

  // monitor
  logic prev_rst = 1'b0;
  int   run_len = 0;
  bit   pin_bad = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_rst = 1'b0; run_len = 0; pin_bad = 1'b0;
    end else begin
      if (int_rst) begin
        run_len++;
        if (q.size() > 0 && q[0].jtag) begin
          if (rst_out !== jtag_rstout_lvl) pin_bad = 1'b1;
        end else if (rst_out !== 1'b1) pin_bad = 1'b1;
      end
      if (!prev_rst && int_rst && q.size() == 0)
        check(1'b0, "R11 spurious reset", 1, 0);
      if (prev_rst && !int_rst && q.size() > 0) begin
        got = q.pop_front();
        check(rst_status == got.status, "R7/R8 status", int'(rst_status), int'(got.status));
        check(run_len == got.len, "R4/R5/R6 reset length", run_len, got.len);
        check(wake_cfg_q == got.wake, "R3 wake capture", int'(wake_cfg_q), int'(got.wake));
        check(pll_cfg_q == got.pll, "R3 pll capture", int'(pll_cfg_q), int'(got.pll));
        check(boot_cfg_q == got.boot, "R6 boot sample", int'(boot_cfg_q), int'(got.boot));
        check(!pin_bad, got.jtag ? "R10 rst_out follows level" : "R2 rst_out with int_rst",
              int'(pin_bad), 0);
        check(rst_out == 1'b0, "R6 rst_out released", int'(rst_out), 0);
        run_len = 0; pin_bad = 1'b0;
      end
      prev_rst = int_rst;
    end
  end

  function automatic logic [3:0] top_rank(input logic [3:0] s);
    for (int i = 0; i < 4; i++) if (s[i]) return 4'(1 << i);
    return 4'b0;
  endfunction

  task automatic wait_drain();
    while (q.size() != 0) tick();
    tick();
  endtask

  // src bits: 0 clock loss, 1 lock loss, 2 watchdog, 3 scan reset
  task automatic fire(input logic [3:0] src, input int hold, input int extra, input int n,
                      input logic [WAKE_W-1:0] wv, input logic [PLL_W-1:0] pv,
                      input logic [BOOT_W-1:0] bv);
    exp_t e;
    int m;
    m = (n == 0) ? 1 : n;
    e.status = top_rank(src);
    e.len    = hold + extra + m + 5;
    e.wake = wv; e.pll = pv; e.boot = bv; e.jtag = e.status[3];
    q.push_back(e);
    clk_loss_rst_en = 1'b1; jtag_en = 1'b1;
    wait_n = CNT_W'(n); boot_cfg_pins = ~bv;
    tick();
    wake_cfg_in = wv; pll_cfg_in = pv;
    req_clk_loss = src[0]; req_lock_loss = src[1]; req_wdog_dbg = src[2]; jtag_rst_instr = src[3];
    tick();
    wake_cfg_in = ~wv; pll_cfg_in = ~pv;
    if (extra > 0) req_lock_loss = 1'b1;
    repeat (hold - 1) tick();
    req_clk_loss = 1'b0; req_wdog_dbg = 1'b0; jtag_rst_instr = 1'b0;
    if (extra == 0) req_lock_loss = 1'b0;
    repeat (extra) tick();
    req_lock_loss = 1'b0;
    repeat (m + 1) tick();
    boot_cfg_pins = bv;
    tick();
    boot_cfg_pins = ~bv;
    wait_drain();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog timeout", 0, 1);
    summary();
    $finish;
  end

  initial begin
    exp_t e;
    rst_n = 1'b0; wait_n = '0;
    req_lock_loss = 0; req_clk_loss = 0; clk_loss_rst_en = 0; req_wdog_dbg = 0;
    jtag_en = 0; jtag_rst_instr = 0; jtag_rstout_lvl = 0;
    wake_cfg_in = '0; pll_cfg_in = '0; boot_cfg_pins = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick(); tick();
    // R1
    check(int_rst == 1'b0, "R1 int_rst after reset", int'(int_rst), 0);
    check(rst_out == 1'b0, "R1 rst_out after reset", int'(rst_out), 0);
    check(rst_status == 4'b0, "R1 status after reset", int'(rst_status), 0);

    // R11: gated clock loss and disabled scan port have no effect
    clk_loss_rst_en = 1'b0; req_clk_loss = 1'b1;
    jtag_en = 1'b0; jtag_rst_instr = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick();
      check(int_rst == 1'b0 && rst_out == 1'b0, "R11 gated request ignored", int'(int_rst), 0);
    end
    req_clk_loss = 1'b0; jtag_rst_instr = 1'b0;
    tick(); tick();
    check(rst_status == 4'b0, "R11 status untouched", int'(rst_status), 0);

    // R2/R5: lock loss, several counts including zero
    fire(4'b0010, 3, 0, 3,  4'hA, 2'b01, 6'h2D);
    fire(4'b0100, 2, 0, 0,  4'h5, 2'b10, 6'h13);
    fire(4'b0001, 4, 0, 12, 4'h3, 2'b11, 6'h3C);
    // R8: simultaneous requests
    fire(4'b0111, 3, 0, 2,  4'hC, 2'b01, 6'h07);
    fire(4'b1110, 2, 0, 1,  4'h9, 2'b10, 6'h21);
    // R4: lock loss lingers after the watchdog request leaves
    fire(4'b0100, 3, 5, 2,  4'h6, 2'b11, 6'h18);
    // R10: scan reset, reset-out driven by test controller level
    fire(4'b1000, 4, 0, 3,  4'hE, 2'b00, 6'h35);

    // R9: watchdog request arriving mid-count restarts and becomes the cause
    e.status = 4'b0100; e.len = 4 + 2 + 8 + 5;
    e.wake = 4'h7; e.pll = 2'b10; e.boot = 6'h2A; e.jtag = 1'b0;
    q.push_back(e);
    wait_n = CNT_W'(8); boot_cfg_pins = ~6'h2A;
    tick(); req_lock_loss = 1'b1; wake_cfg_in = 4'h1; pll_cfg_in = 2'b01;
    tick(); wake_cfg_in = 4'hF;
    tick(); req_lock_loss = 1'b0;
    tick();
    tick(); req_wdog_dbg = 1'b1; wake_cfg_in = 4'h7; pll_cfg_in = 2'b10;
    tick(); wake_cfg_in = 4'h0; pll_cfg_in = 2'b00;
    tick(); req_wdog_dbg = 1'b0;
    repeat (9) tick();
    boot_cfg_pins = 6'h2A;
    tick();
    boot_cfg_pins = ~6'h2A;
    wait_drain();

    // R7: status stays between resets
    repeat (4) tick();
    check(rst_status == 4'b0100, "R7 status held while idle", int'(rst_status), 4);

    summary();
    $finish;
  end

endmodule